// File: doc/BRIEF.md
# First-Order Single-Bit Noise-Shaping Modulator

This block turns a stream of signed fixed-point samples into a one-bit stream whose local average follows the input. It is the digital form of a first-order delta-sigma loop. A saturating accumulator integrates the difference between the input sample and the fed-back output level. The sign of the accumulator picks the next output bit, and the two-level feedback is ideal.

The integrator delays by one sample. At each accepted sample the new accumulator value is formed from the input accepted at the previous strobe and from the output level that was current before the update. The signal path is therefore a one-sample delay, and the quantization error is shaped by a first difference. Samples are accepted only on cycles where the valid strobe is high, so the update rate is set by the strobe and not by the clock. Any oversampling ratio from 8 to 256 is served by pacing the strobe.

The full quantizer levels are ±16384 on the 16-bit input scale. The loop stays stable for inputs within 80 % of that, which is ±13107. A registered flag reports any accepted sample outside this band. If such samples are held long enough to push the accumulator toward its 20-bit limits, the accumulator clips instead of wrapping.

Top module: `noise_shaper_1b`

## Requirements
- R1: After reset, and until the first valid strobe, `bit_out` is 1 (the cleared accumulator counts as non-negative) and `range_err` is 0.
- R2: Each strobe updates the accumulator as acc_new = acc_old + x_prev − fb. Here x_prev is the sample accepted at the preceding strobe (0 right after reset) and fb is +16384 when `bit_out` is 1 and −16384 when it is 0. So after reset, two strobes of 20000 give outputs 0 then 1.
- R3: `bit_out` is 1 exactly when the accumulator is non-negative. With a zero input after reset, the output alternates 0, 1, 0, 1, starting with 0 at the first strobe.
- R4: For a constant input x with |x| ≤ 13107, taken as two's complement where ±16384 means the two quantizer levels, the number of ones in 256 consecutive updates after 8 settling updates is within 1 of 128 + x/128.
- R5: On each strobe `range_err` is loaded with 1 if the sample is greater than 13107 or less than −13107, and with 0 otherwise.
- R6: While `in_valid` is low the accumulator, the delayed sample, `bit_out` and `range_err` all hold, whatever value `in_sample` carries.
- R7: The accumulator clips to [−524288, 524287]. After a long run of 32767 it sits at the top. Strobes of 0 then give exactly 32 ones before the first 0. The mirror case, a long run of −32768, gives exactly 32 zeros before the first 1.
- R8: Exactly one update happens per strobe. Spacing strobes with idle cycles between them leaves the R4 ones count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| in_valid | input | 1 | Sample strobe; one loop update per high cycle |
| in_sample | input | 16 | Signed input sample, ±16384 equal to the quantizer levels |
| bit_out | output | 1 | Modulator output bit, 1 for the positive level |
| range_err | output | 1 | Last accepted sample lay outside ±13107 |

## Verification
The overflow properties assume that a run of large samples and a matching output level always move the accumulator toward its limit, never across zero. This holds only while the accumulator clips, so the bench drives long full-scale runs to force that case. The zero-input toggle property assumes the accumulator has just reached 0 or −16384, which is where a zero input settles. The zero test therefore starts from reset. The density tests keep their samples on multiples of 128 inside ±13107, so each expected count is an exact integer and the accumulator stays within one step of its steady band.

// File: rtl/nshape_pkg.sv
package nshape_pkg;
  typedef enum logic {
    LVL_NEG = 1'b0,
    LVL_POS = 1'b1
  } lvl_e;

  localparam int RST_STAGES = 2;
endpackage

// File: rtl/nshape_rst_sync.sv
module nshape_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/nshape_range_chk.sv
module nshape_range_chk #(
  parameter int IN_W  = 16,
  parameter int LIMIT = 13107
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strobe,
  input  logic signed [IN_W-1:0] x_in,
  output logic                   flag_q
);
  logic over_hi;
  logic over_lo;
  logic flag_n;

  always_comb begin
    over_hi = (x_in > LIMIT);
    over_lo = (x_in < -LIMIT);
    flag_n  = flag_q;
    if (strobe) flag_n = over_hi | over_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_n;
  end

  // R5: an out-of-band sample is reported after the strobe
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && ((x_in > LIMIT) || (x_in < -LIMIT))) |=> flag_q);

  // R6: without a strobe the flag keeps its value
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(flag_q));
endmodule

// File: rtl/nshape_integ.sv
module nshape_integ #(
  parameter int IN_W      = 16,
  parameter int ACC_W     = 20,
  parameter int HALF_STEP = 16384
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strobe,
  input  logic signed [IN_W-1:0]  x_in,
  input  logic                    fb_pos,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [ACC_W-1:0] acc_n
);
  localparam int SUM_W = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] ACC_MAX  = SUM_W'((1 <<< (ACC_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] ACC_MIN  = -ACC_MAX - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] FB_LEVEL = SUM_W'(HALF_STEP);

  logic signed [IN_W-1:0]  xd_q;
  logic signed [IN_W-1:0]  xd_n;
  logic signed [SUM_W-1:0] acc_ext;
  logic signed [SUM_W-1:0] x_ext;
  logic signed [SUM_W-1:0] sum;
  logic signed [ACC_W-1:0] acc_sat;

  always_comb begin
    acc_ext = {{(SUM_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
    x_ext   = {{(SUM_W-IN_W){xd_q[IN_W-1]}}, xd_q};
    sum     = fb_pos ? (acc_ext + x_ext - FB_LEVEL) : (acc_ext + x_ext + FB_LEVEL);
    if (sum > ACC_MAX)      acc_sat = ACC_MAX[ACC_W-1:0];
    else if (sum < ACC_MIN) acc_sat = ACC_MIN[ACC_W-1:0];
    else                    acc_sat = sum[ACC_W-1:0];
    acc_n = acc_q;
    xd_n  = xd_q;
    if (strobe) begin
      acc_n = acc_sat;
      xd_n  = x_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      xd_q  <= '0;
    end else begin
      acc_q <= acc_n;
      xd_q  <= xd_n;
    end
  end

  // R7: a large positive push from a non-negative state must not wrap negative
  assert_no_wrap_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !acc_q[ACC_W-1] && (xd_q >= HALF_STEP)) |=> !acc_q[ACC_W-1]);

  // R7: mirror case on the negative side
  assert_no_wrap_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && acc_q[ACC_W-1] && (xd_q <= -HALF_STEP)) |=> acc_q[ACC_W-1]);

  // R6: no strobe, no state change
  assert_state_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(acc_q) && $stable(xd_q)));

  // R3: zero input at the settled points flips the sign each update
  assert_zero_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && (xd_q == 0) && ((acc_q == 0) || (acc_q == -HALF_STEP)))
      |=> (acc_q[ACC_W-1] != $past(acc_q[ACC_W-1])));
endmodule

// File: rtl/nshape_quant.sv
module nshape_quant
  import nshape_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic acc_sign_n,
  input  logic acc_sign_q,
  output logic y_q
);
  lvl_e lvl_q;
  lvl_e lvl_n;

  always_comb begin
    lvl_n = lvl_q;
    if (strobe) lvl_n = acc_sign_n ? LVL_NEG : LVL_POS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= LVL_POS;
    else        lvl_q <= lvl_n;
  end

  assign y_q = (lvl_q == LVL_POS);

  // R3: the output level always matches the accumulator sign
  assert_sign_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    y_q == !acc_sign_q);
endmodule

// File: rtl/noise_shaper_1b.sv
module noise_shaper_1b #(
  parameter int IN_W      = 16,
  parameter int ACC_W     = 20,
  parameter int HALF_STEP = 16384,
  parameter int RANGE_NUM = 4,
  parameter int RANGE_DEN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_sample,
  output logic            bit_out,
  output logic            range_err
);
  localparam int LIMIT = (HALF_STEP * RANGE_NUM) / RANGE_DEN;

  logic                    rst_n_s;
  logic signed [IN_W-1:0]  x_s;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_n;
  logic                    y_q;

  assign x_s = in_sample;

  nshape_rst_sync #(.STAGES(nshape_pkg::RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  nshape_range_chk #(.IN_W(IN_W), .LIMIT(LIMIT)) u_range (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .strobe (in_valid),
    .x_in   (x_s),
    .flag_q (range_err)
  );

  nshape_integ #(.IN_W(IN_W), .ACC_W(ACC_W), .HALF_STEP(HALF_STEP)) u_integ (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .strobe (in_valid),
    .x_in   (x_s),
    .fb_pos (y_q),
    .acc_q  (acc_q),
    .acc_n  (acc_n)
  );

  nshape_quant u_quant (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .strobe     (in_valid),
    .acc_sign_n (acc_n[ACC_W-1]),
    .acc_sign_q (acc_q[ACC_W-1]),
    .y_q        (y_q)
  );

  assign bit_out = y_q;
endmodule

// File: tb/sim_noise_shaper_1b.sv
module sim_noise_shaper_1b;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_sample;
  logic        bit_out;
  logic        range_err;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  noise_shaper_1b u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .bit_out(bit_out), .range_err(range_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0; in_sample = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic push(input int x, output bit b);
    in_sample = 16'(x); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    b = bit_out;
  endtask

  task automatic count_ones(input int x, input int gap, output int ones);
    bit b;
    ones = 0;
    for (int i = 0; i < 264; i++) begin
      push(x, b);
      if (i >= 8) ones += int'(b);
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(bit_out == 1'b1, "R1 bit_out after reset", int'(bit_out), 1);
    chk(range_err == 1'b0, "R1 range_err after reset", int'(range_err), 0);
    in_sample = 16'h7fff;
    repeat (5) @(negedge clk);
    chk(bit_out == 1'b1, "R1 bit_out idle after reset", int'(bit_out), 1);
  endtask

  task automatic t_delay();
    bit b;
    do_reset();
    push(20000, b); chk(b == 1'b0, "R2 first update uses zero delayed sample", int'(b), 0);
    push(20000, b); chk(b == 1'b1, "R2 second update", int'(b), 1);
  endtask

  task automatic t_zero();
    bit b;
    int bad = 0;
    do_reset();
    for (int i = 0; i < 16; i++) begin
      push(0, b);
      if (int'(b) != (i % 2)) bad++;
    end
    chk(bad == 0, "R3 zero input alternation mismatches", bad, 0);
  endtask

  task automatic t_density(input int x, input int gap, input string req);
    int ones;
    int exp;
    do_reset();
    count_ones(x, gap, ones);
    exp = 128 + x / 128;
    chk((ones >= exp - 1) && (ones <= exp + 1), req, ones, exp);
  endtask

  task automatic t_range();
    bit b;
    do_reset();
    push(13107, b);  chk(range_err == 1'b0, "R5 +13107 in band", int'(range_err), 0);
    push(13108, b);  chk(range_err == 1'b1, "R5 +13108 out of band", int'(range_err), 1);
    push(-13107, b); chk(range_err == 1'b0, "R5 -13107 in band", int'(range_err), 0);
    push(-13108, b); chk(range_err == 1'b1, "R5 -13108 out of band", int'(range_err), 1);
    push(-32768, b); chk(range_err == 1'b1, "R5 -32768 out of band", int'(range_err), 1);
    in_sample = 16'd0;
    repeat (3) @(negedge clk);
    chk(range_err == 1'b1, "R6 flag held without strobe", int'(range_err), 1);
    push(0, b);      chk(range_err == 1'b0, "R5 zero clears flag", int'(range_err), 0);
  endtask

  task automatic t_hold();
    bit b;
    int bad = 0;
    do_reset();
    for (int i = 0; i < 5; i++) push(0, b);
    in_sample = 16'h7fff;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bit_out != 1'b0 || range_err != 1'b0) bad++;
    end
    chk(bad == 0, "R6 outputs moved while idle", bad, 0);
    push(0, b); chk(b == 1'b1, "R6 resume step 1", int'(b), 1);
    push(0, b); chk(b == 1'b0, "R6 resume step 2", int'(b), 0);
    push(0, b); chk(b == 1'b1, "R6 resume step 3", int'(b), 1);
  endtask

  task automatic t_sat(input bit pos);
    bit b;
    int wrong = 0;
    int first = -1;
    bit run_lvl;
    do_reset();
    run_lvl = pos;
    for (int i = 0; i < 100; i++) begin
      push(pos ? 32767 : -32768, b);
      if (i > 0 && b != run_lvl) wrong++;
    end
    chk(wrong == 0, pos ? "R7 positive run wrapped" : "R7 negative run wrapped", wrong, 0);
    for (int i = 0; i < 40; i++) begin
      push(0, b);
      if (first < 0 && b != run_lvl) first = i;
    end
    chk(first == 32, pos ? "R7 ones before first zero" : "R7 zeros before first one", first, 32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..R8 run incomplete actual=150000 expected=<150000 cycles");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_delay();
    t_zero();
    t_density(0, 0, "R4 ones count x=0");
    t_density(12800, 0, "R4 ones count x=12800");
    t_density(-12800, 0, "R4 ones count x=-12800");
    t_density(6400, 0, "R4 ones count x=6400");
    t_density(-3200, 0, "R4 ones count x=-3200");
    t_density(6400, 3, "R8 ones count with sparse strobe x=6400");
    t_density(-9600, 2, "R8 ones count with sparse strobe x=-9600");
    t_range();
    t_hold();
    t_sat(1'b1);
    t_sat(1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule